// File: doc/BRIEF.md
# Edge-Period Manchester Response Decoder

This block turns a low-frequency tag's load-modulation response into a 32-bit payload. It sees the modulation as a synchronized digital level and gets a one-cycle tick for every carrier period. After the reader finishes sending, a start pulse arms the block. The block waits a listen delay. It then times the carrier periods between successive level changes and classifies each interval as one or two half-bit samples. It pairs the samples into Manchester bits, checks a five-bit header of ones, and collects the payload.

A frame ends after a long stretch with no edge. An odd sample count is completed with one extra sample at the resting level. If no edge arrives soon enough after the listen delay, the block reports that the tag is silent. A mode selected at start time halves the data rate for anti-collision replies: each payload bit is then the AND of two received bits. The outcome is given as a one-cycle done pulse with exactly one of three flags: valid, error or silent. The outcome and the payload are held until the next result.

Top module: `mhd_response_decoder`

## Requirements
- R1: After reset, resp_done, resp_valid, resp_error and resp_silent are 0 and resp_payload is zero.
- R2: For LISTEN_TICKS ticks after start, the input is ignored. The level present at the last of those ticks is the reference level, so toggles during the listen window do not disturb decoding.
- R3: If the level does not leave the reference within FIRST_TMO (128) ticks after the listen window, the block gives a done pulse with resp_silent=1. An edge that arrives just before that limit is still decoded.
- R4: The first edge yields exactly one sample, at the level that preceded it. Each later edge closes a run of N ticks. A run of 1 to SHORT_MAX (24) ticks yields one sample and a run of 25 to RUN_MAX (64) yields two, all at the level of the run.
- R5: RUN_MAX ticks without an edge end the frame. If the sample count is then odd, one sample at the current level is appended before pairing.
- R6: Samples pair in arrival order. The pair (1,0) decodes to bit 1 and (0,1) to bit 0. A pair of equal samples sets resp_error.
- R7: The first five decoded bits must all be 1. Otherwise the frame ends with resp_error.
- R8: In normal mode the 32 bits after the header form resp_payload, with the first received bit in bit 31. Later bits are ignored. Fewer than 37 decoded bits give resp_error.
- R9: ac_mode is captured at start. In anti-collision mode, 64 bits follow the header and payload bit 31-k is the AND of received data bits 2k and 2k+1. Fewer than 69 decoded bits give resp_error.
- R10: A frame whose sample count would exceed 8*FRAME_BYTES+5 (149 by default) ends with resp_error.
- R11: Each frame produces one single-cycle resp_done. At most one of valid, error and silent is set. The flags and the payload change only with resp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse at the end of the reader's transmission |
| tick | input | 1 | One-cycle pulse per carrier period |
| ac_mode | input | 1 | Anti-collision rate mode, sampled at start |
| mod_in | input | 1 | Synchronized tag modulation level |
| resp_done | output | 1 | One-cycle pulse when a result is ready |
| resp_valid | output | 1 | Frame decoded without fault |
| resp_error | output | 1 | Frame ended with a fault |
| resp_silent | output | 1 | No tag response seen |
| resp_payload | output | 32 | Decoded payload |

## Verification
Frames are sent with half-bit lengths of 13, 16 and 24 ticks. These show that single runs up to 24 and double runs from 26 to 48 are classified correctly. A 12-tick half makes a double run of exactly 24, which must be taken as one sample and must fail the bit count. Data patterns ending in 0 and in 1 separate the padded case from the edge-closed case. Anti-collision frames, bad headers, a forced equal pair, a mid-frame stall, an oversize frame, a late first edge and listen-window glitches each separate one fault or flag from the others.

// File: rtl/mhd_pkg.sv
// Shared types for the edge-period Manchester response decoder.
package mhd_pkg;
    // Phases of the edge sampler after a start pulse
    typedef enum logic [1:0] {
        SM_IDLE   = 2'd0,
        SM_LISTEN = 2'd1,
        SM_WAIT   = 2'd2,
        SM_RUN    = 2'd3
    } smp_state_t;
endpackage

// File: rtl/mhd_edge_sampler.sv
// Edge sampler: waits the listen delay, then times carrier ticks between
// level changes and emits zero, one or two half-bit samples per edge.
// Assumes mod_in is already synchronized to clk; it is examined only on ticks.
module mhd_edge_sampler
    import mhd_pkg::*;
#(
    parameter int LISTEN_TICKS = 140,
    parameter int FIRST_TMO    = 128,
    parameter int SHORT_MAX    = 24,
    parameter int RUN_MAX      = 64,
    parameter int MAX_SAMPLES  = 149
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tick,
    input  logic       mod_in,
    output logic [1:0] smp_n,
    output logic       smp_val,
    output logic       frm_end,
    output logic       frm_silent,
    output logic       frm_ovf,
    output logic       cur_lvl
);
    localparam int CW  = $clog2(LISTEN_TICKS + FIRST_TMO + RUN_MAX + 1);
    localparam int SCW = $clog2(MAX_SAMPLES + 3);
    localparam logic [CW-1:0]  LISTEN_LAST = CW'(LISTEN_TICKS - 1);
    localparam logic [CW-1:0]  FIRST_LAST  = CW'(FIRST_TMO - 1);
    localparam logic [CW-1:0]  RUN_LAST    = CW'(RUN_MAX - 1);
    localparam logic [CW:0]    SHORT_L     = (CW+1)'(SHORT_MAX);
    localparam logic [SCW-1:0] SMP_LIMIT   = SCW'(MAX_SAMPLES);

    smp_state_t     st;
    logic [CW-1:0]  cnt;
    logic [SCW-1:0] scnt;
    logic           lvl;
    logic [CW:0]    run_len;
    logic [1:0]     n_new;
    logic [SCW-1:0] scnt_next;

    // Classify the run being closed by an edge at this tick
    always_comb begin
        run_len   = {1'b0, cnt} + 1'b1;
        n_new     = (run_len <= SHORT_L) ? 2'd1 : 2'd2;
        scnt_next = scnt + SCW'(n_new);
    end

    // Listen delay, first-edge wait, run timing and frame end detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= SM_IDLE;
            cnt        <= '0;
            scnt       <= '0;
            lvl        <= 1'b0;
            smp_n      <= 2'd0;
            smp_val    <= 1'b0;
            frm_end    <= 1'b0;
            frm_silent <= 1'b0;
            frm_ovf    <= 1'b0;
        end else begin
            smp_n      <= 2'd0;
            frm_end    <= 1'b0;
            frm_silent <= 1'b0;
            frm_ovf    <= 1'b0;
            if (start) begin
                st   <= SM_LISTEN;
                cnt  <= '0;
                scnt <= '0;
            end else if (tick) begin
                case (st)
                    SM_LISTEN: begin
                        if (cnt == LISTEN_LAST) begin
                            st  <= SM_WAIT;
                            cnt <= '0;
                            lvl <= mod_in;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SM_WAIT: begin
                        if (mod_in != lvl) begin
                            smp_n   <= 2'd1;
                            smp_val <= lvl;
                            lvl     <= mod_in;
                            cnt     <= '0;
                            scnt    <= SCW'(1);
                            st      <= SM_RUN;
                        end else if (cnt == FIRST_LAST) begin
                            frm_end    <= 1'b1;
                            frm_silent <= 1'b1;
                            st         <= SM_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SM_RUN: begin
                        if (mod_in != lvl) begin
                            if (scnt_next > SMP_LIMIT) begin
                                frm_end <= 1'b1;
                                frm_ovf <= 1'b1;
                                st      <= SM_IDLE;
                            end else begin
                                smp_n   <= n_new;
                                smp_val <= lvl;
                                lvl     <= mod_in;
                                cnt     <= '0;
                                scnt    <= scnt_next;
                            end
                        end else if (cnt == RUN_LAST) begin
                            frm_end <= 1'b1;
                            st      <= SM_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= SM_IDLE;
                endcase
            end
        end
    end

    assign cur_lvl = lvl;
endmodule

// File: rtl/mhd_pair_decoder.sv
// Pair decoder: joins half-bit samples two at a time into Manchester bits,
// pads an odd leftover sample with the current level at frame end.
// Assumes samples and frame end never arrive in the same cycle.
module mhd_pair_decoder (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] smp_n,
    input  logic       smp_val,
    input  logic       frm_end,
    input  logic       frm_silent,
    input  logic       frm_ovf,
    input  logic       pad_lvl,
    output logic       bit_stb,
    output logic       bit_val,
    output logic       bit_bad,
    output logic       fin,
    output logic       fin_silent,
    output logic       fin_ovf
);
    logic pend;
    logic pend_val;
    logic first;
    logic second;

    // Form a bit from the pending sample and the newest sample (or pad)
    always_comb begin
        bit_stb = 1'b0;
        first   = smp_val;
        second  = smp_val;
        if (frm_end) begin
            bit_stb = pend;
            first   = pend_val;
            second  = pad_lvl;
        end else if (smp_n == 2'd1) begin
            bit_stb = pend;
            first   = pend_val;
        end else if (smp_n == 2'd2) begin
            bit_stb = 1'b1;
            first   = pend ? pend_val : smp_val;
        end
        bit_val = first & ~second;
        bit_bad = bit_stb & (first == second);
    end

    // Track the unpaired sample and delay frame end by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= 1'b0;
            pend_val   <= 1'b0;
            fin        <= 1'b0;
            fin_silent <= 1'b0;
            fin_ovf    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                pend <= 1'b0;
            end else if (frm_end) begin
                pend       <= 1'b0;
                fin        <= 1'b1;
                fin_silent <= frm_silent;
                fin_ovf    <= frm_ovf;
            end else if (smp_n == 2'd1) begin
                pend     <= ~pend;
                pend_val <= smp_val;
            end else if (smp_n == 2'd2) begin
                pend_val <= smp_val;
            end
        end
    end
endmodule

// File: rtl/mhd_frame_assembler.sv
// Frame assembler: checks the header of ones, gathers payload bits (or ANDed
// bit pairs in anti-collision mode) and issues the held result flags.
// Assumes bits never arrive in the same cycle as fin.
module mhd_frame_assembler #(
    parameter int HDR_BITS = 5,
    parameter int PAY_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                ac_mode,
    input  logic                bit_stb,
    input  logic                bit_val,
    input  logic                bit_bad,
    input  logic                fin,
    input  logic                fin_silent,
    input  logic                fin_ovf,
    output logic                resp_done,
    output logic                resp_valid,
    output logic                resp_error,
    output logic                resp_silent,
    output logic [PAY_BITS-1:0] resp_payload
);
    localparam int BW = $clog2(HDR_BITS + 2 * PAY_BITS + 1);
    localparam logic [BW-1:0] HDR_L  = BW'(HDR_BITS);
    localparam logic [BW-1:0] NEED_N = BW'(HDR_BITS + PAY_BITS);
    localparam logic [BW-1:0] NEED_A = BW'(HDR_BITS + 2 * PAY_BITS);

    logic                ac_q;
    logic [BW-1:0]       bcnt;
    logic                bad_q;
    logic                hdr_bad;
    logic                half_q;
    logic                half_v;
    logic [PAY_BITS-1:0] acc;
    logic [BW-1:0]       need;
    logic                failed;

    // Bit count needed for the captured mode and the overall fault verdict
    always_comb begin
        need   = ac_q ? NEED_A : NEED_N;
        failed = bad_q | hdr_bad | fin_ovf | (bcnt < need);
    end

    // Collect header and payload bits, publish the outcome on fin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q         <= 1'b0;
            bcnt         <= '0;
            bad_q        <= 1'b0;
            hdr_bad      <= 1'b0;
            half_q       <= 1'b0;
            half_v       <= 1'b0;
            acc          <= '0;
            resp_done    <= 1'b0;
            resp_valid   <= 1'b0;
            resp_error   <= 1'b0;
            resp_silent  <= 1'b0;
            resp_payload <= '0;
        end else begin
            resp_done <= 1'b0;
            if (start) begin
                ac_q    <= ac_mode;
                bcnt    <= '0;
                bad_q   <= 1'b0;
                hdr_bad <= 1'b0;
                half_q  <= 1'b0;
                acc     <= '0;
            end else begin
                if (bit_stb) begin
                    if (bit_bad) bad_q <= 1'b1;
                    if (bcnt < HDR_L) begin
                        if (!bit_val) hdr_bad <= 1'b1;
                    end else if (bcnt < need) begin
                        if (!ac_q) begin
                            acc <= {acc[PAY_BITS-2:0], bit_val};
                        end else if (!half_q) begin
                            half_q <= 1'b1;
                            half_v <= bit_val;
                        end else begin
                            half_q <= 1'b0;
                            acc    <= {acc[PAY_BITS-2:0], half_v & bit_val};
                        end
                    end
                    if (bcnt < NEED_A) bcnt <= bcnt + 1'b1;
                end
                if (fin) begin
                    resp_done    <= 1'b1;
                    resp_silent  <= fin_silent;
                    resp_valid   <= ~fin_silent & ~failed;
                    resp_error   <= ~fin_silent & failed;
                    resp_payload <= acc;
                end
            end
        end
    end
endmodule

// File: rtl/mhd_response_decoder.sv
// Top of the response decoder: edge sampler, pair decoder and frame
// assembler in a chain. Assumes mod_in is synchronous to clk.
module mhd_response_decoder #(
    parameter int LISTEN_TICKS = 140,
    parameter int FIRST_TMO    = 128,
    parameter int SHORT_MAX    = 24,
    parameter int RUN_MAX      = 64,
    parameter int FRAME_BYTES  = 18,
    parameter int HDR_BITS     = 5,
    parameter int PAY_BITS     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                tick,
    input  logic                ac_mode,
    input  logic                mod_in,
    output logic                resp_done,
    output logic                resp_valid,
    output logic                resp_error,
    output logic                resp_silent,
    output logic [PAY_BITS-1:0] resp_payload
);
    localparam int MAX_SAMPLES = 8 * FRAME_BYTES + HDR_BITS;

    logic [1:0] smp_n;
    logic       smp_val;
    logic       frm_end;
    logic       frm_silent;
    logic       frm_ovf;
    logic       cur_lvl;
    logic       bit_stb;
    logic       bit_val;
    logic       bit_bad;
    logic       fin;
    logic       fin_silent;
    logic       fin_ovf;

    mhd_edge_sampler #(
        .LISTEN_TICKS(LISTEN_TICKS),
        .FIRST_TMO   (FIRST_TMO),
        .SHORT_MAX   (SHORT_MAX),
        .RUN_MAX     (RUN_MAX),
        .MAX_SAMPLES (MAX_SAMPLES)
    ) i_sampler (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .mod_in(mod_in),
        .smp_n(smp_n), .smp_val(smp_val), .frm_end(frm_end),
        .frm_silent(frm_silent), .frm_ovf(frm_ovf), .cur_lvl(cur_lvl)
    );

    mhd_pair_decoder i_pairs (
        .clk(clk), .rst_n(rst_n), .start(start),
        .smp_n(smp_n), .smp_val(smp_val), .frm_end(frm_end),
        .frm_silent(frm_silent), .frm_ovf(frm_ovf), .pad_lvl(cur_lvl),
        .bit_stb(bit_stb), .bit_val(bit_val), .bit_bad(bit_bad),
        .fin(fin), .fin_silent(fin_silent), .fin_ovf(fin_ovf)
    );

    mhd_frame_assembler #(
        .HDR_BITS(HDR_BITS),
        .PAY_BITS(PAY_BITS)
    ) i_frame (
        .clk(clk), .rst_n(rst_n), .start(start), .ac_mode(ac_mode),
        .bit_stb(bit_stb), .bit_val(bit_val), .bit_bad(bit_bad),
        .fin(fin), .fin_silent(fin_silent), .fin_ovf(fin_ovf),
        .resp_done(resp_done), .resp_valid(resp_valid),
        .resp_error(resp_error), .resp_silent(resp_silent),
        .resp_payload(resp_payload)
    );
endmodule

// File: rtl/mhd_response_decoder_chk.sv
// Checker for the response decoder: result flag and pulse rules, and the
// sample hand-off between sampler and pair decoder.
module mhd_response_decoder_chk #(
    parameter int PAY_BITS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                resp_done,
    input logic                resp_valid,
    input logic                resp_error,
    input logic                resp_silent,
    input logic [PAY_BITS-1:0] resp_payload,
    input logic [1:0]          smp_n,
    input logic                frm_end
);
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_valid, resp_error, resp_silent}));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);

    a_r11_payload_held: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_done |-> $stable(resp_payload));

    a_r11_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_done |-> $stable({resp_valid, resp_error, resp_silent}));

    a_r4_two_samples_max: assert property (@(posedge clk) disable iff (!rst_n)
        smp_n != 2'd3);

    a_r5_end_apart: assert property (@(posedge clk) disable iff (!rst_n)
        frm_end |-> (smp_n == 2'd0));
endmodule

bind mhd_response_decoder mhd_response_decoder_chk #(.PAY_BITS(PAY_BITS)) i_chk (
    .clk(clk), .rst_n(rst_n), .resp_done(resp_done), .resp_valid(resp_valid),
    .resp_error(resp_error), .resp_silent(resp_silent),
    .resp_payload(resp_payload), .smp_n(smp_n), .frm_end(frm_end)
);

// File: tb/test_mhd_response_decoder.sv
module test_mhd_response_decoder;
    localparam int LISTEN = 140;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tick = 1'b1;
    logic        ac_mode = 1'b0;
    logic        mod_in = 1'b1;
    logic        resp_done;
    logic        resp_valid;
    logic        resp_error;
    logic        resp_silent;
    logic [31:0] resp_payload;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mhd_response_decoder i_mhd_response_decoder (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .ac_mode(ac_mode), .mod_in(mod_in), .resp_done(resp_done),
        .resp_valid(resp_valid), .resp_error(resp_error),
        .resp_silent(resp_silent), .resp_payload(resp_payload)
    );

    typedef struct packed {
        logic        ac;
        logic [7:0]  half;
        logic [7:0]  lead;
        logic [4:0]  hdr;
        logic [6:0]  nbits;
        logic [63:0] raw;
        logic        ok;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd16, 8'd10,  5'h1F, 7'd32, {32'hA5A5F00F, 32'h0}, 1'b1},
        '{1'b0, 8'd13, 8'd40,  5'h1F, 7'd32, 64'h0,                 1'b1},
        '{1'b0, 8'd24, 8'd5,   5'h1F, 7'd32, {32'hFFFF0001, 32'h0}, 1'b1},
        '{1'b0, 8'd12, 8'd10,  5'h1F, 7'd32, 64'h0,                 1'b0},
        '{1'b1, 8'd16, 8'd20,  5'h1F, 7'd64, 64'hF0F03C3CFFFF00A6,  1'b1},
        '{1'b0, 8'd16, 8'd10,  5'h1D, 7'd32, {32'h12345678, 32'h0}, 1'b0},
        '{1'b0, 8'd16, 8'd15,  5'h1F, 7'd40, {32'h12345678, 8'hFF, 24'h0}, 1'b1},
        '{1'b0, 8'd16, 8'd120, 5'h1F, 7'd32, {32'hDEADBEEF, 32'h0}, 1'b1},
        '{1'b1, 8'd16, 8'd10,  5'h1F, 7'd32, {32'hFFFFFFFF, 32'h0}, 1'b0}
    };

    logic hv [0:255];
    int   hn;

    int          seen;
    logic        got_v, got_e, got_s;
    logic [31:0] got_p;

    // Latch every result pulse seen at the outputs
    always @(negedge clk) begin
        if (resp_done) begin
            seen  <= seen + 1;
            got_v <= resp_valid;
            got_e <= resp_error;
            got_s <= resp_silent;
            got_p <= resp_payload;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic add_bit(input logic b);
        hv[hn] = b;
        hv[hn+1] = ~b;
        hn += 2;
    endtask

    task automatic build(input logic [4:0] hdr, input int nbits, input logic [63:0] raw);
        hn = 0;
        for (int i = 4; i >= 0; i--) add_bit(hdr[i]);
        for (int i = 0; i < nbits; i++) add_bit(i < 64 ? raw[63-i] : 1'b1);
    endtask

    function automatic logic [31:0] exp_pay(input logic ac, input logic [63:0] raw);
        logic [31:0] p;
        if (!ac) return raw[63:32];
        for (int j = 0; j < 32; j++) p[31-j] = raw[63-2*j] & raw[62-2*j];
        return p;
    endfunction

    function automatic string vtag(input int i);
        case (i)
            0: return "R8 R5 mixed data";
            1: return "R4 half 13";
            2: return "R4 half 24";
            3: return "R4 double run of 24";
            4: return "R9 anti-collision";
            5: return "R7 bad header";
            6: return "R8 extra bits";
            7: return "R3 late first edge";
            default: return "R9 short anti-collision";
        endcase
    endfunction

    task automatic run_frame(input logic ac, input int half, input int lead,
                             input int stall_at, input int stall_len, input logic glitch);
        @(negedge clk);
        seen = 0;
        start = 1'b1; ac_mode = ac; mod_in = 1'b1;
        @(negedge clk);
        start = 1'b0; ac_mode = ~ac;
        for (int i = 0; i < LISTEN + lead; i++) begin
            @(negedge clk);
            if (glitch && i == 50) mod_in = 1'b0;
            if (glitch && i == 70) mod_in = 1'b1;
        end
        for (int k = 1; k < hn; k++) begin
            mod_in = hv[k];
            repeat (half + ((k == stall_at) ? stall_len : 0)) @(negedge clk);
        end
        mod_in = 1'b1;
        repeat (400) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 done", {31'b0, resp_done}, 32'd0);
        check("R1 flags", {29'b0, resp_valid, resp_error, resp_silent}, 32'd0);
        check("R1 payload", resp_payload, 32'd0);

        // Table of frames
        for (int v = 0; v < NV; v++) begin
            build(VECS[v].hdr, int'(VECS[v].nbits), VECS[v].raw);
            run_frame(VECS[v].ac, int'(VECS[v].half), int'(VECS[v].lead), -1, 0, 1'b0);
            check({"R11 one done: ", vtag(v)}, seen, 32'd1);
            check({"valid: ", vtag(v)}, {31'b0, got_v}, {31'b0, VECS[v].ok});
            check({"error: ", vtag(v)}, {31'b0, got_e}, {31'b0, ~VECS[v].ok});
            if (VECS[v].ok)
                check({"payload: ", vtag(v)}, got_p, exp_pay(VECS[v].ac, VECS[v].raw));
        end

        // R3 silent tag
        hn = 1;
        run_frame(1'b0, 16, 0, -1, 0, 1'b0);
        check("R3 silent one done", seen, 32'd1);
        check("R3 silent flags", {29'b0, got_v, got_e, got_s}, 32'b001);

        // R2 toggles inside the listen window are ignored
        build(5'h1F, 32, {32'h0F1E2D3C, 32'h0});
        run_frame(1'b0, 16, 10, -1, 0, 1'b1);
        check("R2 glitch valid", {31'b0, got_v}, 32'd1);
        check("R2 glitch payload", got_p, 32'h0F1E2D3C);

        // R6 equal pair after the header
        hn = 0;
        for (int i = 0; i < 5; i++) add_bit(1'b1);
        hv[hn] = 1'b1; hv[hn+1] = 1'b1; hn += 2;
        for (int i = 0; i < 32; i++) add_bit(i[0]);
        run_frame(1'b0, 16, 10, -1, 0, 1'b0);
        check("R6 equal pair error", {30'b0, got_v, got_e}, 32'b01);

        // R5 a run past RUN_MAX ends the frame early
        build(5'h1F, 32, {32'hA5A5F00F, 32'h0});
        run_frame(1'b0, 16, 10, 20, 60, 1'b0);
        check("R5 stall one done", seen, 32'd1);
        check("R5 stall error", {30'b0, got_v, got_e}, 32'b01);

        // R10 oversize frame overflows the sample limit
        build(5'h1F, 75, {32'h13579BDF, 32'h0});
        run_frame(1'b0, 16, 10, -1, 0, 1'b0);
        check("R10 overflow error", {30'b0, got_v, got_e}, 32'b01);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule